// File: doc/BRIEF.md
# Programmable Wait-State Static Bus Sequencer

This block times accesses to six external memory segments that sit behind a static, SRAM-style bus. Each segment holds its own 8-bit setting, which gives its data width, whether page mode is on, the wait count for an access that opens a new address, and a shorter wait count for sequential (burst) accesses. A requester presents a segment number, a sequential flag, a transfer size and the write data. The sequencer runs a wait counter for each bus beat, cuts a transfer that is wider than the segment into several beats taken from the low bytes upward, and raises a one-cycle completion pulse once the last beat is over.

Settings are written one segment at a time through a small write port. A request is taken only while the block is idle. The segment setting, size, sequential flag and data are captured when the request is taken, so later writes or changes on the request inputs cannot disturb a transfer that is already running. Address decoding and memory models belong to the surrounding logic.

Top module: `static_bus_seq`

## Requirements
- R1: After reset, `busy`, `beat_ack` and `done` are 0, and every segment setting reads as 0xFA: 32-bit width, page mode off, 8 non-sequential waits, 3 sequential waits.
- R2: A setting write with `cfg_we`=1 stores `cfg_data` into segment `cfg_idx` (0..5) only. A write with an index of 6 or 7 changes no segment.
- R3: Setting byte layout: bits [1:0] width (0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit), bit [2] page enable, bits [5:3] non-sequential code, bits [7:6] sequential waits. A beat that uses the non-sequential count waits code+1 cycles (1..8), and the beat lasts waits+1 cycles.
- R4: With page mode on and `req_seq`=1, the first beat waits the sequential count (0..3). A count of 0 gives a one-cycle beat.
- R5: With page mode off, `req_seq` has no effect, and every beat uses the non-sequential count.
- R6: `req_size` is 0 = byte, 1 = halfword, 2 or 3 = word. The number of beats is size bytes / width bytes when that is more than 1, and 1 otherwise. A word takes 2 beats on a 16-bit segment and 4 on an 8-bit segment.
- R7: Beats after the first use the sequential count when page mode is on, and the non-sequential count when it is off.
- R8: During beat i, `bus_wdata` holds `req_wdata` shifted right by i times the width in bits, masked to the smaller of the size and the width, with the upper bits zero. Beats run from the low bytes upward.
- R9: `beat_ack` is high in the final cycle of each beat. `done` is high for exactly one cycle, the cycle after the last beat's final cycle. The time from the accepting clock edge to the edge that raises `done` equals the sum of all beat lengths.
- R10: A request is taken only when `busy`=0. A request held during a transfer does not change its timing or data, and `busy` is 0 in the `done` cycle.
- R11: `beat_idx` gives the current beat number. It starts at 0 and goes up by one at each beat boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setting write enable |
| cfg_idx | input | 3 | Segment index for the setting write |
| cfg_data | input | 8 | Setting byte |
| req_valid | input | 1 | Request present |
| req_seg | input | 3 | Segment to access |
| req_seq | input | 1 | Sequential (burst) access flag |
| req_size | input | 2 | Transfer size code |
| req_wdata | input | 32 | Write data for the whole transfer |
| busy | output | 1 | Transfer in progress |
| beat_ack | output | 1 | Final cycle of the current beat |
| beat_idx | output | 2 | Current beat number |
| bus_wdata | output | 32 | Data lane for the current beat |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every width, page setting, non-sequential code, sequential count, sequential flag and size. It measures each latency edge by edge, so a wait count that is off by one, such as using the raw code instead of code+1, shows up at once. Zero-wait sequential beats and page-off requests with the sequential flag set are the cases where a design that chose the wrong count would finish early or late. Multi-beat words on narrow segments expose a wrong beat count, a wrong byte order and a wrong count on later beats. During every transfer the bench changes the request inputs and keeps the request valid, so a design that takes a request while busy shows a wrong beat count or wrong data. Writes to segments 6 and 7, and a per-segment check after writing distinct settings, catch decoding that aliases segments or ignores the index.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int BUS_W   = 32;
  localparam int CFG_W   = 8;
  localparam int NSEQ_W  = 3;
  localparam int SEQ_W   = 2;
  localparam int WAIT_W  = NSEQ_W + 1;
  localparam int IDX_W   = 2;
  localparam int BEAT_W  = IDX_W + 1;

  typedef struct packed {
    logic [SEQ_W-1:0]  seq_wait;
    logic [NSEQ_W-1:0] nseq_code;
    logic              page_en;
    logic [1:0]        width;
  } seg_cfg_t;

  localparam logic [CFG_W-1:0] CFG_RESET = 8'hFA;

  function automatic logic [1:0] log_bytes(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  function automatic logic [BEAT_W-1:0] beat_count(input logic [1:0] wcode,
                                                   input logic [1:0] scode);
    logic [1:0] wl;
    logic [1:0] sl;
    wl = log_bytes(wcode);
    sl = log_bytes(scode);
    if (sl > wl) return BEAT_W'(1 << (sl - wl));
    return BEAT_W'(1);
  endfunction

  function automatic logic [BUS_W-1:0] lane_slice(input logic [BUS_W-1:0] data,
                                                  input logic [1:0] wcode,
                                                  input logic [1:0] scode,
                                                  input logic [IDX_W-1:0] idx);
    logic [1:0] wl;
    logic [1:0] sl;
    logic [1:0] ml;
    logic [BUS_W-1:0] mask;
    int sh;
    wl = log_bytes(wcode);
    sl = log_bytes(scode);
    ml = (sl < wl) ? sl : wl;
    sh = int'(idx) * (8 << wl);
    case (ml)
      2'd0:    mask = 32'h0000_00FF;
      2'd1:    mask = 32'h0000_FFFF;
      default: mask = 32'hFFFF_FFFF;
    endcase
    return (data >> sh) & mask;
  endfunction
endpackage

// File: rtl/sbs_cfg_bank.sv
module sbs_cfg_bank
  import sbs_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int SEG_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEG_W-1:0] widx,
  input  logic [CFG_W-1:0] wdata,
  input  logic [SEG_W-1:0] ridx,
  output seg_cfg_t         rcfg
);
  logic [CFG_W-1:0] regs [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= CFG_RESET;
      else if (we && int'(widx) == g)
        regs[g] <= wdata;
    end
  end

  always_comb begin
    rcfg = seg_cfg_t'(CFG_RESET);
    for (int i = 0; i < NUM_SEG; i++)
      if (int'(ridx) == i) rcfg = seg_cfg_t'(regs[i]);
  end
endmodule

// File: rtl/sbs_wait_sel.sv
module sbs_wait_sel
  import sbs_pkg::*;
(
  input  seg_cfg_t          cfg,
  input  logic              first_beat,
  input  logic              seq_flag,
  output logic [WAIT_W-1:0] waits
);
  logic use_seq;

  always_comb begin
    use_seq = cfg.page_en && (!first_beat || seq_flag);
    if (use_seq)
      waits = WAIT_W'(cfg.seq_wait);
    else
      waits = WAIT_W'(cfg.nseq_code) + WAIT_W'(1);
  end
endmodule

// File: rtl/sbs_beat_engine.sv
module sbs_beat_engine
  import sbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_seq,
  input  logic [1:0]        req_size,
  input  logic [BUS_W-1:0]  req_wdata,
  input  seg_cfg_t          live_cfg,
  output logic              busy,
  output logic              beat_ack,
  output logic [IDX_W-1:0]  beat_idx,
  output logic [BUS_W-1:0]  bus_wdata,
  output logic              done
);
  seg_cfg_t          cfg_q;
  logic              seq_q;
  logic [1:0]        size_q;
  logic [BUS_W-1:0]  data_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [IDX_W-1:0]  last_q;
  logic              accept;
  seg_cfg_t          sel_cfg;
  logic [WAIT_W-1:0] load_waits;
  logic [IDX_W-1:0]  next_idx;
  logic [BEAT_W-1:0] nbeats;

  assign accept   = req_valid && !busy;
  assign sel_cfg  = busy ? cfg_q : live_cfg;
  assign next_idx = beat_idx + IDX_W'(1);
  assign nbeats   = beat_count(live_cfg.width, req_size);

  sbs_wait_sel u_wait_sel (
    .cfg        (sel_cfg),
    .first_beat (!busy),
    .seq_flag   (busy ? seq_q : req_seq),
    .waits      (load_waits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      beat_ack  <= 1'b0;
      done      <= 1'b0;
      beat_idx  <= '0;
      bus_wdata <= '0;
      cfg_q     <= seg_cfg_t'(CFG_RESET);
      seq_q     <= 1'b0;
      size_q    <= '0;
      data_q    <= '0;
      cnt_q     <= '0;
      last_q    <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        cfg_q     <= live_cfg;
        seq_q     <= req_seq;
        size_q    <= req_size;
        data_q    <= req_wdata;
        last_q    <= IDX_W'(nbeats - BEAT_W'(1));
        beat_idx  <= '0;
        cnt_q     <= load_waits;
        beat_ack  <= (load_waits == '0);
        bus_wdata <= lane_slice(req_wdata, live_cfg.width, req_size, '0);
      end else if (busy) begin
        if (cnt_q != '0) begin
          cnt_q    <= cnt_q - WAIT_W'(1);
          beat_ack <= (cnt_q == WAIT_W'(1));
        end else if (beat_idx == last_q) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          beat_ack  <= 1'b0;
          beat_idx  <= '0;
          bus_wdata <= '0;
        end else begin
          beat_idx  <= next_idx;
          cnt_q     <= load_waits;
          beat_ack  <= (load_waits == '0);
          bus_wdata <= lane_slice(data_q, cfg_q.width, size_q, next_idx);
        end
      end else begin
        beat_ack <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/static_bus_seq.sv
module static_bus_seq
  import sbs_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int SEG_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEG_W-1:0]  cfg_idx,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic              req_seq,
  input  logic [1:0]        req_size,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              busy,
  output logic              beat_ack,
  output logic [IDX_W-1:0]  beat_idx,
  output logic [BUS_W-1:0]  bus_wdata,
  output logic              done
);
  seg_cfg_t live_cfg;

  sbs_cfg_bank #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_cfg_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .widx  (cfg_idx),
    .wdata (cfg_data),
    .ridx  (req_seg),
    .rcfg  (live_cfg)
  );

  sbs_beat_engine u_engine (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_seq   (req_seq),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .live_cfg  (live_cfg),
    .busy      (busy),
    .beat_ack  (beat_ack),
    .beat_idx  (beat_idx),
    .bus_wdata (bus_wdata),
    .done      (done)
  );
endmodule

// File: rtl/static_bus_seq_chk.sv
module static_bus_seq_chk
  import sbs_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             beat_ack,
  input logic [IDX_W-1:0] beat_idx,
  input logic             done
);
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(beat_ack)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_BUSY_DROP_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
  AST_ACK_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    beat_ack |-> busy); // R10
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(beat_ack)) |-> $stable(beat_idx)); // R11
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && $past(beat_ack)) |-> (beat_idx == $past(beat_idx) + 2'd1)); // R11
endmodule

bind static_bus_seq static_bus_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .beat_ack (beat_ack),
  .beat_idx (beat_idx),
  .done     (done)
);

// File: tb/test_static_bus_seq.sv
`timescale 1ns/1ps
module test_static_bus_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [7:0]  cfg_data;
  logic        req_valid;
  logic [2:0]  req_seg;
  logic        req_seq;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        busy;
  logic        beat_ack;
  logic [1:0]  beat_idx;
  logic [31:0] bus_wdata;
  logic        done;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  static_bus_seq i_static_bus_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_seg(req_seg), .req_seq(req_seq), .req_size(req_size),
    .req_wdata(req_wdata), .busy(busy), .beat_ack(beat_ack), .beat_idx(beat_idx),
    .bus_wdata(bus_wdata), .done(done)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int bytes_of(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_lane(input logic [31:0] d, input int wc, input int sz, input int i);
    int wb;
    int sb;
    int m;
    logic [31:0] v;
    wb = bytes_of(wc);
    sb = bytes_of(sz);
    m  = (sb < wb) ? sb : wb;
    v  = d >> (i * wb * 8);
    if (m == 4) return v;
    return v & ((32'h1 << (8 * m)) - 32'h1);
  endfunction

  task automatic wr_cfg(input int s, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(s); cfg_data = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input int s, input bit rs, input int sz, input int wc,
                     input int exp_cyc, input int exp_beats, input string tag);
    logic [31:0] d;
    int n;
    int acks;
    d = $urandom;
    @(negedge clk);
    req_valid = 1'b1; req_seg = 3'(s); req_seq = rs; req_size = 2'(sz); req_wdata = d;
    @(posedge clk);
    n = 0; acks = 0;
    @(negedge clk);
    req_seg = 3'((s + 1) % 6); req_seq = ~rs; req_size = 2'((sz + 1) % 3); req_wdata = ~d;
    if (beat_ack) begin
      chk(beat_idx == 2'(acks), "R11", beat_idx, acks);
      chk(bus_wdata == exp_lane(d, wc, sz, acks), "R8", bus_wdata, exp_lane(d, wc, sz, acks));
      acks++;
    end
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      if (beat_ack) begin
        chk(beat_idx == 2'(acks), "R11", beat_idx, acks);
        chk(bus_wdata == exp_lane(d, wc, sz, acks), "R8", bus_wdata, exp_lane(d, wc, sz, acks));
        acks++;
      end
    end while (!done && n < 200);
    req_valid = 1'b0;
    chk(n == exp_cyc, tag, n, exp_cyc);
    chk(acks == exp_beats, "R6", acks, exp_beats);
    chk(busy == 1'b0, "R10 busy in done cycle", busy, 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9 R10 single done, no stray accept", {busy, done}, 0);
  endtask

  initial begin
    while (cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k;
    rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_data = '0;
    req_valid = 1'b0; req_seg = '0; req_seq = 1'b0; req_size = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk({busy, beat_ack, done} == 3'b000, "R1 outputs", {busy, beat_ack, done}, 0);
    // R1: default setting -> 32-bit, page off, 8 waits: word takes 9 cycles, 1 beat
    run(2, 1'b1, 2, 2, 9, 1, "R1 default setting");

    // Full sweep R3 R4 R5 R6 R7
    k = 0;
    for (int wc = 0; wc < 3; wc++)
      for (int pg = 0; pg < 2; pg++)
        for (int nc = 0; nc < 8; nc++)
          for (int sc = 0; sc < 4; sc++)
            for (int rs = 0; rs < 2; rs++)
              for (int sz = 0; sz < 3; sz++) begin
                int s;
                int wf;
                int wl;
                int nb;
                int tot;
                string tag;
                s  = k % 6;
                k++;
                wr_cfg(s, {2'(sc), 3'(nc), 1'(pg), 2'(wc)});
                wf = (pg == 1 && rs == 1) ? sc : nc + 1;
                wl = (pg == 1) ? sc : nc + 1;
                nb = (bytes_of(sz) > bytes_of(wc)) ? bytes_of(sz) / bytes_of(wc) : 1;
                tot = (wf + 1) + (nb - 1) * (wl + 1);
                if (nb > 1) tag = "R7 later-beat waits";
                else if (pg == 0 && rs == 1) tag = "R5 page off ignores seq";
                else if (pg == 1 && rs == 1) tag = "R4 sequential waits";
                else tag = "R3 non-seq waits";
                run(s, 1'(rs), sz, wc, tot, nb, tag);
              end

    // R2: distinct settings per segment, out-of-range writes ignored
    for (int s = 0; s < 6; s++) wr_cfg(s, {2'd0, 3'(s), 1'b0, 2'd2});
    wr_cfg(6, 8'h00);
    wr_cfg(7, 8'h00);
    for (int s = 0; s < 6; s++) run(s, 1'b0, 2, 2, s + 2, 1, "R2 per-segment setting");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule